// File: doc/BRIEF.md
# DRAM command priority scheduler

This block is the command selection stage of a memory controller. In every cycle it looks at five command classes and grants at most one of them. The classes are refresh, column access (CAS), scrub, read and write. The grant goes to the highest-ranked class that is eligible, and the choice is combinational from the current inputs and the internal state.

Refresh and scrub requests are made inside the block. Each comes from its own interval counter, whose period is set at a port. A request made this way stays pending until it is granted. The counter then starts over.

Two rules can make a class ineligible:
- **Activate limit.** A command that must first open a row is held back while four row activates already fall within the last activate window.
- **Read-after-write hazard.** A read is held back while its address equals the address of any valid pending write slot. This keeps the read from overtaking that write.

Neither rule stops a lower-ranked class from being granted in the same cycle.

Top module: `dram_cmd_sched`

## Requirements
- R1: `grant` is one-hot or all zero in every cycle. The bit positions are [0] refresh, [1] CAS, [2] scrub, [3] read and [4] write.
- R2: Among the eligible classes, the grant goes to the first one in this fixed order: refresh, CAS, scrub, read, write. A CAS, read or write request is eligible when its request input is high and neither the activate limit nor the hazard rule blocks it.
- R3: `act` is high exactly when the granted class has its activate flag set (`cas_act`, `rd_act` or `wr_act`). A class with its flag set is not eligible in a cycle in which it would make a fifth activate within any FAW_WIN consecutive cycles. An activate in cycle t is allowed when the fourth most recent activate happened at cycle t-FAW_WIN or earlier. While a class is blocked this way, a lower class with no activate flag can still be granted.
- R4: A read is not eligible while `rd_addr` equals the address of any slot k whose `wr_valid[k]` is high. Slot k's address is `wr_addr[k*ADDR_W +: ADDR_W]`. Slots with `wr_valid` low are ignored. A write is not affected by this rule.
- R5: The refresh request becomes pending in cycle `ref_interval` after reset release, where the first cycle after release is cycle 0. If the refresh is granted in cycle g, the next refresh request becomes pending in cycle g+1+`ref_interval`. `ref_interval` is REF_W bits wide (13 by default) and must be at least 1.
- R6: The scrub request follows the same timing as R5, using `scrub_interval`. That input is SCRUB_W bits wide (12 by default).
- R7: A pending refresh or scrub request stays pending in every cycle in which it is not granted, for example a scrub that loses to a refresh. It clears in the cycle after its grant.
- R8: During reset and directly after it, `grant` and `act` are zero when no request is present. Directly after reset, up to four activates are allowed in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_interval | input | REF_W | Refresh period in cycles |
| scrub_interval | input | SCRUB_W | Scrub period in cycles |
| cas_req | input | 1 | CAS request |
| cas_act | input | 1 | The CAS request needs a row activate |
| rd_req | input | 1 | Read request |
| rd_act | input | 1 | The read request needs a row activate |
| rd_addr | input | ADDR_W | Read address |
| wr_req | input | 1 | Write request |
| wr_act | input | 1 | The write request needs a row activate |
| wr_valid | input | N_WR | Valid flag for each pending write slot |
| wr_addr | input | N_WR*ADDR_W | Pending write addresses, with slot k at [k*ADDR_W +: ADDR_W] |
| grant | output | 5 | One-hot grant, bit positions as in R1 |
| act | output | 1 | Row activate strobe for the granted command |

## Verification
The bench builds the block with ADDR_W=8, N_WR=4 and FAW_WIN=6. Under these settings:
- All combinations of the CAS, read and write requests are swept.
- Each write slot is tried with a matching address, with a mismatching address, and with a matching address on an invalid slot.
- Several full activate windows fit into a few dozen cycles, with the activate flag held high and also toggled.
- With refresh and scrub intervals of 5 and 3, collisions between refresh, scrub and reads recur every few cycles. The bench runs many such periods and checks each grant against an arithmetic model of the interval counters.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;

  localparam int N_CLASS = 5;
  localparam int K_REF   = 0;
  localparam int K_CAS   = 1;
  localparam int K_SCRUB = 2;
  localparam int K_RD    = 3;
  localparam int K_WR    = 4;

  // Isolate the lowest set bit: lower index means higher rank.
  function automatic logic [N_CLASS-1:0] pick_first(input logic [N_CLASS-1:0] elig);
    return elig & (~elig + 1'b1);
  endfunction

  // Saturating age increment.
  function automatic int unsigned age_inc(input int unsigned a, input int unsigned lim);
    return (a >= lim) ? lim : a + 1;
  endfunction

endpackage

// File: rtl/interval_gen.sv
module interval_gen #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] interval,
  input  logic             gnt,
  output logic             pend
);
  logic [CNT_W-1:0] cnt_q;
  logic             expire;

  assign expire = !pend && (cnt_q == interval - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pend  <= 1'b0;
    end else if (pend) begin
      if (gnt) pend <= 1'b0;
    end else if (expire) begin
      pend  <= 1'b1;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R7: an ungranted request is held
  a_r7_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !gnt) |=> pend);
  // R7: a grant clears the request
  a_r7_grant_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && gnt) |=> !pend);
  // R2: a grant only comes for a pending request
  a_r2_gnt_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    gnt |-> pend);
endmodule

// File: rtl/faw_limiter.sv
module faw_limiter #(
  parameter int FAW_WIN = 16,
  parameter int FAW_CNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_fire,
  output logic act_ok
);
  import dram_sched_pkg::*;

  localparam int AGE_W = $clog2(FAW_WIN + 1);

  // Age in cycles of each of the most recent activates, saturating at FAW_WIN.
  logic [AGE_W-1:0] age_q [FAW_CNT];

  assign act_ok = (age_q[FAW_CNT-1] >= AGE_W'(FAW_WIN));

  for (genvar g = 0; g < FAW_CNT; g++) begin : g_age
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        age_q[g] <= AGE_W'(FAW_WIN);
      end else if (act_fire) begin
        if (g == 0) age_q[g] <= AGE_W'(1);
        else        age_q[g] <= AGE_W'(age_inc(int'(age_q[(g == 0) ? 0 : g-1]), FAW_WIN));
      end else begin
        age_q[g] <= AGE_W'(age_inc(int'(age_q[g]), FAW_WIN));
      end
    end
  end

  // R3: an activate is only issued when the window allows it
  a_r3_window: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |-> act_ok);
  // R3: the newest age restarts after an activate
  a_r3_age_restart: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |=> (age_q[0] == AGE_W'(1)));
endmodule

// File: rtl/raw_detect.sv
module raw_detect #(
  parameter int ADDR_W = 32,
  parameter int N_WR   = 8
) (
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [N_WR-1:0]        wr_valid,
  input  logic [N_WR*ADDR_W-1:0] wr_addr,
  output logic                   hit
);
  logic [N_WR-1:0] slot_match;

  for (genvar k = 0; k < N_WR; k++) begin : g_slot
    assign slot_match[k] = wr_valid[k] && (wr_addr[k*ADDR_W +: ADDR_W] == rd_addr);
  end

  assign hit = |slot_match;
endmodule

// File: rtl/dram_cmd_sched.sv
module dram_cmd_sched #(
  parameter int ADDR_W  = 32,
  parameter int N_WR    = 8,
  parameter int FAW_WIN = 16,
  parameter int FAW_CNT = 4,
  parameter int REF_W   = 13,
  parameter int SCRUB_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [REF_W-1:0]       ref_interval,
  input  logic [SCRUB_W-1:0]     scrub_interval,
  input  logic                   cas_req,
  input  logic                   cas_act,
  input  logic                   rd_req,
  input  logic                   rd_act,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic                   wr_req,
  input  logic                   wr_act,
  input  logic [N_WR-1:0]        wr_valid,
  input  logic [N_WR*ADDR_W-1:0] wr_addr,
  output logic [4:0]             grant,
  output logic                   act
);
  import dram_sched_pkg::*;

  logic ref_pend, scrub_pend, act_ok, raw_hit;
  logic [N_CLASS-1:0] elig;

  interval_gen #(.CNT_W(REF_W)) u_ref_gen (
    .clk(clk), .rst_n(rst_n), .interval(ref_interval),
    .gnt(grant[K_REF]), .pend(ref_pend));

  interval_gen #(.CNT_W(SCRUB_W)) u_scrub_gen (
    .clk(clk), .rst_n(rst_n), .interval(scrub_interval),
    .gnt(grant[K_SCRUB]), .pend(scrub_pend));

  faw_limiter #(.FAW_WIN(FAW_WIN), .FAW_CNT(FAW_CNT)) u_faw (
    .clk(clk), .rst_n(rst_n), .act_fire(act), .act_ok(act_ok));

  raw_detect #(.ADDR_W(ADDR_W), .N_WR(N_WR)) u_raw (
    .rd_addr(rd_addr), .wr_valid(wr_valid), .wr_addr(wr_addr), .hit(raw_hit));

  always_comb begin
    elig          = '0;
    elig[K_REF]   = ref_pend;
    elig[K_CAS]   = cas_req && (!cas_act || act_ok);
    elig[K_SCRUB] = scrub_pend;
    elig[K_RD]    = rd_req && !raw_hit && (!rd_act || act_ok);
    elig[K_WR]    = wr_req && (!wr_act || act_ok);
  end

  assign grant = pick_first(elig);
  assign act   = (grant[K_CAS] && cas_act) || (grant[K_RD] && rd_act) ||
                 (grant[K_WR] && wr_act);

  // R1: one grant at most
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R2: a pending refresh always wins
  a_r2_ref_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> grant[K_REF]);
  // R2: an unblocked CAS wins when no refresh is pending
  a_r2_cas_next: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_req && (!cas_act || act_ok) && !ref_pend) |-> grant[K_CAS]);
  // R3: the activate strobe comes only with a grant
  a_r3_act_granted: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> ($countones(grant) == 1));
  // R4: no read issued past a matching pending write
  a_r4_no_raw: assert property (@(posedge clk) disable iff (!rst_n)
    raw_hit |-> !grant[K_RD]);
endmodule

// File: tb/dram_cmd_sched_bench.sv
module dram_cmd_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 8;
  localparam int NW  = 4;
  localparam int FAW = 6;

  localparam logic [4:0] G_REF = 5'b00001, G_CAS = 5'b00010, G_SCR = 5'b00100,
                         G_RD  = 5'b01000, G_WR  = 5'b10000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [12:0] ref_interval = 13'h1FFF;
  logic [11:0] scrub_interval = 12'hFFF;
  logic cas_req = 0, cas_act = 0, rd_req = 0, rd_act = 0, wr_req = 0, wr_act = 0;
  logic [AW-1:0] rd_addr = '0;
  logic [NW-1:0] wr_valid = '0;
  logic [NW*AW-1:0] wr_addr = '0;
  logic [4:0] grant;
  logic act;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_cmd_sched #(.ADDR_W(AW), .N_WR(NW), .FAW_WIN(FAW)) u_dram_cmd_sched (
    .clk(clk), .rst_n(rst_n), .ref_interval(ref_interval), .scrub_interval(scrub_interval),
    .cas_req(cas_req), .cas_act(cas_act), .rd_req(rd_req), .rd_act(rd_act),
    .rd_addr(rd_addr), .wr_req(wr_req), .wr_act(wr_act), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .grant(grant), .act(act));

  task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic check_grant(input string tag, input logic [4:0] exp_g, input logic exp_a);
    check(grant === exp_g, tag, 32'(grant), 32'(exp_g));
    check(act === exp_a, tag, 32'(act), 32'(exp_a));
    check($countones(grant) <= 1, "R1", 32'(grant), 32'(exp_g));
  endtask

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

  initial begin
    int t [4];
    int cyc;
    bit ok;
    logic [4:0] eg;
    logic ea;
    bit rp, sp;
    int rc, sc;
    string tag;

    repeat (3) @(negedge clk);
    #1 check_grant("R8 reset", 5'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #1 check_grant("R8 after reset", 5'b0, 1'b0);
    @(negedge clk);

    // R2 priority sweep over CAS, read and write requests
    for (int m = 0; m < 8; m++) begin
      cas_req = m[0]; rd_req = m[1]; wr_req = m[2];
      #1;
      eg = m[0] ? G_CAS : m[1] ? G_RD : m[2] ? G_WR : 5'b0;
      check_grant("R2 priority", eg, 1'b0);
      @(negedge clk);
    end

    // R4 hazard sweep
    cas_req = 0; rd_req = 1; wr_req = 1;
    for (int k = 0; k < NW; k++) wr_addr[k*AW +: AW] = AW'(8'h40 + k);
    for (int s = 0; s < NW; s++) begin
      for (int mode = 0; mode < 3; mode++) begin
        wr_valid = (mode == 2) ? ~(NW'(1) << s) : (NW'(1) << s);
        rd_addr  = (mode == 1) ? AW'(8'h7F) : AW'(8'h40 + s);
        #1;
        check_grant("R4 hazard", (mode == 0) ? G_WR : G_RD, 1'b0);
        @(negedge clk);
      end
    end
    wr_valid = '0;

    // R3 activate window, R8 first four activates go at once
    for (int q = 0; q < 4; q++) t[q] = -1000;
    cyc = 0;
    rd_req = 1; wr_req = 1; wr_act = 0;
    for (int i = 0; i < 60; i++) begin
      rd_act = (i < 30) ? 1'b1 : (i % 3 == 0);
      #1;
      ok = (cyc - t[3]) >= FAW;
      if (!rd_act)  begin eg = G_RD; ea = 0; end
      else if (ok)  begin eg = G_RD; ea = 1; end
      else          begin eg = G_WR; ea = 0; end
      check_grant((i < 4) ? "R8 initial activates" : "R3 window", eg, ea);
      if (ea) begin
        t[3] = t[2]; t[2] = t[1]; t[1] = t[0]; t[0] = cyc;
      end
      cyc++;
      @(negedge clk);
    end

    // R5/R6/R7 interval generators with a background read
    rst_n = 0; rd_act = 0; wr_req = 0;
    ref_interval = 13'd5; scrub_interval = 12'd3;
    @(negedge clk);
    rst_n = 1;
    rp = 0; sp = 0; rc = 0; sc = 0;
    for (int i = 0; i < 120; i++) begin
      #1;
      eg = rp ? G_REF : sp ? G_SCR : G_RD;
      tag = (rp && sp) ? "R7 held scrub" : rp ? "R5 refresh" : sp ? "R6 scrub" : "R5 R6 idle";
      check_grant(tag, eg, 1'b0);
      if (rp) begin
        rp = 0;
      end else if (rc == 4) begin rp = 1; rc = 0; end
      else rc++;
      if (sp) begin
        if (eg == G_SCR) sp = 0;
      end else if (sc == 2) begin sp = 1; sc = 0; end
      else sc++;
      @(negedge clk);
    end

    finished = 1;
    report();
  end
endmodule